// File: doc/BRIEF.md
# Serial Frame Overhead Output Port

This block sits behind an E3 receive framer and hands the overhead bits of each received frame to downstream logic over one serial wire. It takes the recovered line bit, a bit-valid qualifier and the framer's position count within the frame. It keeps the overhead positions of the frame being received and then plays the completed set out during the following frame. Each overhead bit is held on the output for a fixed slot of receive clock cycles. The block has no clock of its own for the overhead stream. It runs entirely on the receive-section output clock, which is nominally 34.368 MHz and comes from either the line clock or a local oscillator.

Two markers go with the data. The first is a single-cycle capture strobe placed near the middle of each slot. The second is a frame-start flag that covers the whole slot of the first overhead bit. Every output changes only just after a rising edge, so downstream logic can capture the data on a falling edge at which the strobe reads high. A loss-of-frame indication from the framer mutes both markers until a clean frame boundary re-arms the port.

Top module: `ohport_serial`

## Requirements
- R1: During output slot k (k = 0..11), `oh_data` carries the overhead bit that was taken from `rx_bit` at frame position k. It holds that value for every cycle of the slot.
- R2: `oh_strobe` is high for exactly one cycle in each 128-cycle slot while the port is armed, and never for two cycles in a row.
- R3: Slot 0 begins two rising edges after the edge that samples a boundary (`frame_pos` = 0 with `rx_valid` high). Within each slot, the strobe is high on the cycle at offset 64, counting from offset 0.
- R4: `oh_sof` is high for all 128 cycles of slot 0 and low during slots 1 to 11.
- R5: Overhead bits captured during frame N are played out during frame N+1. The bits arriving in the current frame leave the bits being played unchanged.
- R6: A bit at an overhead position that arrives with `rx_valid` low is not captured. That position keeps the value from the last frame in which it arrived valid.
- R7: A boundary that arrives before the previous frame has run its full 1536 cycles restarts the output at slot 0 with the timing of R3.
- R8: From the edge that samples `lof` high, `oh_strobe` and `oh_sof` stay low until a boundary is sampled with `lof` low. Output resumes two edges after that boundary.
- R9: Synchronous active-high `rst` drives all three outputs low at the next edge and clears the stored overhead bits, so the first frame played after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-section output clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered line data bit from the framer |
| rx_valid | input | 1 | Qualifies `rx_bit` and `frame_pos` for this cycle |
| frame_pos | input | 11 | Bit position of `rx_bit` within the 1536-bit frame |
| lof | input | 1 | Loss-of-frame indication from the framer |
| oh_data | output | 1 | Serial overhead bit, one bit per 128-cycle slot |
| oh_strobe | output | 1 | One-cycle capture strobe at mid-slot |
| oh_sof | output | 1 | High during the slot of the first overhead bit |

## Verification
A boundary sampled at one edge shows up as the start of slot 0 only after the following edge, so results lag their stimulus by two edges. The bench therefore maps the position it drives at each falling edge to output offset (position − 2), and wraps to the previous frame's length for positions 0 and 1. Loss of frame acts one edge sooner: the falling edge right after `lof` is driven must already see both markers low. Reset acts at the next edge. The bench compares strobe and frame-start on every falling edge and reports the count of mismatches per slot. It checks the data bit on the falling edge where the strobe should be high, which is where downstream logic would capture it.

// File: rtl/ohport_pkg.sv
package ohport_pkg;

   // Default geometry of one E3 frame and of the overhead playout
   localparam int unsigned DEF_FRAME_LEN  = 1536;
   localparam int unsigned DEF_OH_BITS    = 12;
   localparam int unsigned DEF_SLOT_LEN   = 128;
   localparam int unsigned DEF_STROBE_POS = 64;

   // Arming state of the output markers
   typedef enum logic {
      PACE_DARK = 1'b0,
      PACE_LIVE = 1'b1
   } pace_mode_e;

endpackage

// File: rtl/ohport_capture.sv
module ohport_capture #(
   parameter int unsigned FRAME_LEN = ohport_pkg::DEF_FRAME_LEN,
   parameter int unsigned OH_BITS   = ohport_pkg::DEF_OH_BITS,
   localparam int unsigned POS_W    = $clog2(FRAME_LEN)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rx_bit,
   input  logic               rx_valid,
   input  logic [POS_W-1:0]   frame_pos,
   output logic               boundary,
   output logic [OH_BITS-1:0] hold
);

   logic [OH_BITS-1:0] cap_q;
   logic [OH_BITS-1:0] hold_q;

   assign boundary = rx_valid && (frame_pos == '0);

   // One capture flop per overhead position, written only when that position is valid
   for (genvar i = 0; i < OH_BITS; i++) begin : g_cap
      always_ff @(posedge clk) begin
         if (rst) begin
            cap_q[i] <= 1'b0;
         end else if (rx_valid && (frame_pos == POS_W'(i))) begin
            cap_q[i] <= rx_bit;
         end
      end
   end

   // Completed frame moves to the playout copy at the next boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
      end else if (boundary) begin
         hold_q <= cap_q;
      end
   end

   assign hold = hold_q;

endmodule

// File: rtl/ohport_pacer.sv
module ohport_pacer #(
   parameter int unsigned OH_BITS  = ohport_pkg::DEF_OH_BITS,
   parameter int unsigned SLOT_LEN = ohport_pkg::DEF_SLOT_LEN,
   localparam int unsigned SLOT_W  = $clog2(OH_BITS),
   localparam int unsigned CYC_W   = $clog2(SLOT_LEN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              boundary,
   input  logic              lof,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [CYC_W-1:0]  cyc,
   output logic              live
);

   import ohport_pkg::*;

   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(OH_BITS - 1);
   localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_LEN - 1);

   logic [SLOT_W-1:0] slot_q;
   logic [CYC_W-1:0]  cyc_q;
   pace_mode_e        mode_q;

   // Slot and cycle counters: restart on a boundary, otherwise free-run and wrap
   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
         cyc_q  <= '0;
      end else if (boundary) begin
         slot_q <= '0;
         cyc_q  <= '0;
      end else if (cyc_q == CYC_LAST) begin
         cyc_q  <= '0;
         slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
         cyc_q  <= cyc_q + 1'b1;
      end
   end

   // Loss of frame wins over a boundary seen in the same cycle
   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= PACE_DARK;
      end else if (lof) begin
         mode_q <= PACE_DARK;
      end else if (boundary) begin
         mode_q <= PACE_LIVE;
      end
   end

   assign slot_idx = slot_q;
   assign cyc      = cyc_q;
   assign live     = (mode_q == PACE_LIVE);

endmodule

// File: rtl/ohport_serializer.sv
module ohport_serializer #(
   parameter int unsigned OH_BITS    = ohport_pkg::DEF_OH_BITS,
   parameter int unsigned SLOT_LEN   = ohport_pkg::DEF_SLOT_LEN,
   parameter int unsigned STROBE_POS = ohport_pkg::DEF_STROBE_POS,
   parameter bit          REG_OUT    = 1'b1,
   localparam int unsigned SLOT_W    = $clog2(OH_BITS),
   localparam int unsigned CYC_W     = $clog2(SLOT_LEN)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [OH_BITS-1:0] hold,
   input  logic [SLOT_W-1:0]  slot_idx,
   input  logic [CYC_W-1:0]   cyc,
   input  logic               live,
   input  logic               lof,
   output logic               oh_data,
   output logic               oh_strobe,
   output logic               oh_sof
);

   localparam logic [CYC_W-1:0] CYC_STB = CYC_W'(STROBE_POS);

   logic data_n;
   logic strobe_n;
   logic sof_n;
   logic armed;

   assign armed    = live && !lof;
   assign data_n   = hold[slot_idx];
   assign strobe_n = armed && (cyc == CYC_STB);
   assign sof_n    = armed && (slot_idx == '0);

   if (REG_OUT) begin : g_reg
      logic data_q;
      logic strobe_q;
      logic sof_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            data_q   <= 1'b0;
            strobe_q <= 1'b0;
            sof_q    <= 1'b0;
         end else begin
            data_q   <= data_n;
            strobe_q <= strobe_n;
            sof_q    <= sof_n;
         end
      end

      assign oh_data   = data_q;
      assign oh_strobe = strobe_q;
      assign oh_sof    = sof_q;
   end else begin : g_comb
      assign oh_data   = data_n;
      assign oh_strobe = strobe_n;
      assign oh_sof    = sof_n;
   end

endmodule

// File: rtl/ohport_serial.sv
module ohport_serial #(
   parameter int unsigned FRAME_LEN  = ohport_pkg::DEF_FRAME_LEN,
   parameter int unsigned OH_BITS    = ohport_pkg::DEF_OH_BITS,
   parameter int unsigned SLOT_LEN   = ohport_pkg::DEF_SLOT_LEN,
   parameter int unsigned STROBE_POS = ohport_pkg::DEF_STROBE_POS,
   parameter bit          REG_OUT    = 1'b1,
   localparam int unsigned POS_W     = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_bit,
   input  logic             rx_valid,
   input  logic [POS_W-1:0] frame_pos,
   input  logic             lof,
   output logic             oh_data,
   output logic             oh_strobe,
   output logic             oh_sof
);

   localparam int unsigned SLOT_W = $clog2(OH_BITS);
   localparam int unsigned CYC_W  = $clog2(SLOT_LEN);

   // Elaboration-time parameter checks
   if (FRAME_LEN != OH_BITS * SLOT_LEN) begin : g_bad_geometry
      $error("ohport_serial: slots must tile the frame exactly");
   end
   if (OH_BITS < 2 || OH_BITS > FRAME_LEN) begin : g_bad_oh_bits
      $error("ohport_serial: overhead bit count out of range");
   end
   if (STROBE_POS >= SLOT_LEN) begin : g_bad_strobe
      $error("ohport_serial: strobe offset must lie inside a slot");
   end
   if ((1 << CYC_W) != SLOT_LEN) begin : g_bad_slot_len
      $error("ohport_serial: slot length must be a power of two");
   end

   logic               boundary;
   logic [OH_BITS-1:0] hold;
   logic [SLOT_W-1:0]  slot_idx;
   logic [CYC_W-1:0]   cyc;
   logic               live;

   ohport_capture #(
      .FRAME_LEN (FRAME_LEN),
      .OH_BITS   (OH_BITS)
   ) u_capture (
      .clk       (clk),
      .rst       (rst),
      .rx_bit    (rx_bit),
      .rx_valid  (rx_valid),
      .frame_pos (frame_pos),
      .boundary  (boundary),
      .hold      (hold)
   );

   ohport_pacer #(
      .OH_BITS  (OH_BITS),
      .SLOT_LEN (SLOT_LEN)
   ) u_pacer (
      .clk      (clk),
      .rst      (rst),
      .boundary (boundary),
      .lof      (lof),
      .slot_idx (slot_idx),
      .cyc      (cyc),
      .live     (live)
   );

   ohport_serializer #(
      .OH_BITS    (OH_BITS),
      .SLOT_LEN   (SLOT_LEN),
      .STROBE_POS (STROBE_POS),
      .REG_OUT    (REG_OUT)
   ) u_serializer (
      .clk       (clk),
      .rst       (rst),
      .hold      (hold),
      .slot_idx  (slot_idx),
      .cyc       (cyc),
      .live      (live),
      .lof       (lof),
      .oh_data   (oh_data),
      .oh_strobe (oh_strobe),
      .oh_sof    (oh_sof)
   );

endmodule

// File: rtl/ohport_serial_chk.sv
module ohport_serial_chk #(
   parameter int unsigned FRAME_LEN  = ohport_pkg::DEF_FRAME_LEN,
   parameter int unsigned OH_BITS    = ohport_pkg::DEF_OH_BITS,
   parameter int unsigned SLOT_LEN   = ohport_pkg::DEF_SLOT_LEN,
   parameter int unsigned STROBE_POS = ohport_pkg::DEF_STROBE_POS,
   localparam int unsigned POS_W     = $clog2(FRAME_LEN)
) (
   input logic             clk,
   input logic             rst,
   input logic             rx_valid,
   input logic [POS_W-1:0] frame_pos,
   input logic             lof,
   input logic             oh_data,
   input logic             oh_strobe,
   input logic             oh_sof
);

   localparam int unsigned CYC_W = $clog2(SLOT_LEN);

   // Independent slot-offset tracker: offset 0 lands two edges after a sampled boundary
   logic             bnd_q;
   logic             seen_q;
   logic             rst_q;
   logic [CYC_W-1:0] ofs_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) begin
         bnd_q  <= 1'b0;
         seen_q <= 1'b0;
         ofs_q  <= '0;
      end else begin
         bnd_q <= rx_valid && (frame_pos == '0);
         if (bnd_q) begin
            ofs_q  <= '0;
            seen_q <= 1'b1;
         end else begin
            ofs_q <= (ofs_q == CYC_W'(SLOT_LEN - 1)) ? '0 : ofs_q + 1'b1;
         end
      end
   end

   // R1: the data bit changes only at a slot start
   assert_data_steady_R1: assert property (@(posedge clk) disable iff (rst)
      (seen_q && ofs_q != '0) |-> $stable(oh_data));

   // R2: strobe is a single-cycle pulse
   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
      oh_strobe |=> !oh_strobe);

   // R3, R7: strobe sits at mid-slot relative to the latest boundary
   assert_strobe_mid_R3: assert property (@(posedge clk) disable iff (rst)
      (seen_q && oh_strobe) |-> (ofs_q == CYC_W'(STROBE_POS)));

   // R4: frame-start flag rises only at a slot start
   assert_sof_start_R4: assert property (@(posedge clk) disable iff (rst)
      (seen_q && $rose(oh_sof)) |-> (ofs_q == '0));

   // R8: loss of frame mutes both markers from the next cycle
   assert_lof_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      lof |=> (!oh_strobe && !oh_sof));

   // R9: after a reset edge all outputs are low
   always @(posedge clk) begin
      if (rst_q) begin
         assert_reset_idle_R9: assert (!oh_data && !oh_strobe && !oh_sof);
      end
   end

endmodule

bind ohport_serial ohport_serial_chk #(
   .FRAME_LEN  (FRAME_LEN),
   .OH_BITS    (OH_BITS),
   .SLOT_LEN   (SLOT_LEN),
   .STROBE_POS (STROBE_POS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rx_valid  (rx_valid),
   .frame_pos (frame_pos),
   .lof       (lof),
   .oh_data   (oh_data),
   .oh_strobe (oh_strobe),
   .oh_sof    (oh_sof)
);

// File: tb/ohport_serial_test.sv
module ohport_serial_test;

   localparam int CLK_PERIOD = 10;
   localparam int FRAME      = 1536;
   localparam int NOH        = 12;
   localparam int SLOT       = 128;
   localparam int STB        = 64;
   localparam int NONE       = 4095;

   // {overhead pattern (position 0 in the MSB), frame length, lof position, dropped-valid position}
   localparam int NVEC = 8;
   localparam logic [47:0] VEC [NVEC] = '{
      {12'hF40, 12'd1536, 12'hFFF, 12'hFFF},
      {12'hF42, 12'd1536, 12'hFFF, 12'hFFF},
      {12'h5A5, 12'd1536, 12'hFFF, 12'd5},
      {12'hF41, 12'd1536, 12'd900, 12'hFFF},
      {12'hF43, 12'd800,  12'hFFF, 12'hFFF},
      {12'h0FF, 12'd1536, 12'hFFF, 12'hFFF},
      {12'hF40, 12'd1536, 12'hFFF, 12'hFFF},
      {12'hF42, 12'd1536, 12'hFFF, 12'hFFF}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rx_bit = 1'b0;
   logic        rx_valid = 1'b0;
   logic [10:0] frame_pos = '0;
   logic        lof = 1'b0;
   logic        oh_data;
   logic        oh_strobe;
   logic        oh_sof;

   int n_cmp = 0;
   int n_bad = 0;

   // Bench model state
   logic [NOH-1:0] cap_m, stale_m, snap_m, snap_stale, hold_m, hstale_m;
   bit  dark, dark_next, arm_pend, restart;
   int  prev_len, swaps, st_bad, sof_bad;
   bit  slot_dark;

   ohport_serial uut (
      .clk       (clk),
      .rst       (rst),
      .rx_bit    (rx_bit),
      .rx_valid  (rx_valid),
      .frame_pos (frame_pos),
      .lof       (lof),
      .oh_data   (oh_data),
      .oh_strobe (oh_strobe),
      .oh_sof    (oh_sof)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check_int(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
      end
   endtask

   task automatic model_clear();
      cap_m = '0; stale_m = '0; snap_m = '0; snap_stale = '0;
      hold_m = '0; hstale_m = '0;
      dark = 1'b1; dark_next = 1'b0; arm_pend = 1'b0; restart = 1'b0;
      prev_len = FRAME; swaps = 0; st_bad = 0; sof_bad = 0; slot_dark = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; rx_valid = 1'b0; rx_bit = 1'b0; lof = 1'b0; frame_pos = '0;
      @(negedge clk);
      check_int("R9 data", int'(oh_data), 0);
      check_int("R9 strobe", int'(oh_strobe), 0);
      check_int("R9 sof", int'(oh_sof), 0);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   // One cycle: sample outputs for the previous edge, then drive position p
   task automatic step(input int p, input logic b, input logic v, input logic l);
      int s;
      int slot;
      int w;
      logic exp_st;
      logic exp_sof;
      string tag;
      @(negedge clk);
      if (p == 2 && arm_pend) begin
         hold_m = snap_m; hstale_m = snap_stale;
         dark = 1'b0; arm_pend = 1'b0; swaps++;
      end
      if (dark_next) begin
         dark = 1'b1; dark_next = 1'b0;
      end
      s    = (p >= 2) ? p - 2 : prev_len - 2 + p;
      slot = s / SLOT;
      w    = s % SLOT;
      if (w == 0) begin
         st_bad = 0; sof_bad = 0; slot_dark = 1'b0;
      end
      if (dark) slot_dark = 1'b1;
      exp_st  = !dark && (w == STB);
      exp_sof = !dark && (slot == 0);
      if (oh_strobe !== exp_st) st_bad++;
      if (oh_sof !== exp_sof) sof_bad++;
      if (exp_st) begin
         tag = hstale_m[slot] ? "R6 data" : ((swaps == 1) ? "R9 data" : "R1 R5 data");
         check_int(tag, int'(oh_data), int'(hold_m[slot]));
      end
      if (w == SLOT - 1) begin
         tag = slot_dark ? "R8 strobe" : (restart ? "R7 strobe" : "R2 R3 strobe");
         check_int(tag, st_bad, 0);
         tag = slot_dark ? "R8 sof" : "R4 sof";
         check_int(tag, sof_bad, 0);
      end
      rx_bit = b; rx_valid = v; frame_pos = 11'(p); lof = l;
      if (v && p == 0) begin
         snap_m = cap_m; snap_stale = stale_m; stale_m = '1;
         arm_pend = !l;
      end
      if (v && p < NOH) begin
         cap_m[p] = b; stale_m[p] = 1'b0;
      end
      if (l) dark_next = 1'b1;
   endtask

   task automatic run_frame(input logic [11:0] pat, input int len, input int lof_at, input int drop_at);
      logic b;
      restart = (prev_len != FRAME);
      for (int p = 0; p < len; p++) begin
         b = (p < NOH) ? pat[NOH-1-p] : (p[0] ^ p[4] ^ p[7]);
         step(p, b, (p != drop_at), (p == lof_at));
      end
      prev_len = len;
   endtask

   initial begin
      model_clear();
      do_reset();
      // Table walk: overhead patterns, a dropped valid, a loss of frame, a short frame
      for (int i = 0; i < NVEC; i++) begin
         run_frame(VEC[i][47:36], int'(VEC[i][35:24]), int'(VEC[i][23:12]), int'(VEC[i][11:0]));
      end
      // Directed: reset in mid-run clears stored bits, next frame plays zeros
      do_reset();
      run_frame(12'hF43, FRAME, NONE, NONE);
      run_frame(12'hF40, FRAME, NONE, NONE);
      run_frame(12'hF41, 300, NONE, NONE);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule